// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter that has eight analog inputs behind a multiplexer. A start request carries a 3-bit input number. The sequencer then drives the multiplexer select and opens a sampling window. After that it finds the result one bit at a time, most significant bit first. For each bit it places a trial code on the DAC and reads back a single comparator bit. The finished code goes into a result register and a one-cycle completion pulse is raised.

Every conversion runs on a fixed budget of 160 conversion-clock periods, and the first 12 of them are sampling. A select input, read at the moment the start is accepted, sets the conversion clock to either the system clock or half the system clock. Once sampling is over, the remaining periods are split into eight equal decision slots of 18 periods each. Each bit is resolved at the end of its slot. The 4 periods left over are idle time before completion.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held, and on leaving it, `busy_o`, `done_o` and `sample_o` are low, and `dac_code_o` and `result_o` are 0.
- R2: A start is taken when `start_i` is high and `busy_o` is low. `chan_o` then takes the value of `chan_i` on the next cycle and keeps that value until the conversion ends. Input k is selected by `chan_o` equal to k.
- R3: The clock divider D is 1 when `half_clk_i` = 0 and 2 when `half_clk_i` = 1. It is sampled together with the accepted start. `busy_o` stays high for exactly 160·D system-clock cycles.
- R4: `sample_o` is high for exactly the first 12·D busy cycles. `dac_code_o` is 0 while `sample_o` is high.
- R5: In the busy cycle right after sampling ends, `dac_code_o` is 8'h80, which is the MSB trial.
- R6: The bit in slot j (j = 0 is the MSB) is decided at the end of period 12 + 18·(j+1) − 1. If `comp_low_i` is 1 (input below the DAC level), the bit is cleared; otherwise it is kept. In the same step the next lower bit is set to 1. As a result, the first change of `dac_code_o` after 8'h80 appears at busy cycle (12+18)·D + 1. With an ideal comparator the result equals the largest code that does not exceed the input.
- R7: `done_o` is high for exactly one cycle. That cycle is the first one in which `busy_o` is low again, and `result_o` already holds the new code in it.
- R8: A start that arrives while `busy_o` is high is ignored. The selected channel, the cycle count and the result of the running conversion do not change, and no second conversion follows.
- R9: `result_o` changes only when `done_o` rises. During a conversion it keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 3 | Analog input to convert |
| half_clk_i | input | 1 | 1 = conversion clock is system clock / 2 |
| comp_low_i | input | 1 | Comparator: analog input below DAC level |
| chan_o | output | 3 | Multiplexer select |
| sample_o | output | 1 | Sampling window active |
| dac_code_o | output | 8 | Trial code to the DAC |
| result_o | output | 8 | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A period counter that slips, or a divider phase that is wrong, changes the busy length, the sampling length and the cycle in which the DAC code first moves away from 8'h80. All three are measured on every conversion, so a timing fault shows up within the first 30·D busy cycles. A wrong trial register shows up as a wrong result at the completion pulse. The bench sweeps all 256 input levels, with the other channels set to different values, so a bad decision or a bad channel latch cannot pass unnoticed.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // periods given to each bit decision after sampling
  function automatic int slot_len(int total, int samp, int bits);
    return (total - samp) / bits;
  endfunction

  // true when period c is the last period of a decision slot
  function automatic bit is_decision(int c, int total, int samp, int bits);
    int w;
    w = slot_len(total, samp, bits);
    if (c < samp) return 1'b0;
    if ((c - samp) / w >= bits) return 1'b0;
    return ((c - samp) % w) == (w - 1);
  endfunction

  // bit position (MSB = bits-1) resolved in period c
  function automatic int bit_of(int c, int total, int samp, int bits);
    int w;
    w = slot_len(total, samp, bits);
    return bits - 1 - ((c - samp) / w);
  endfunction
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic half_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= 1'b0;
    else if (!run_i) phase_q <= 1'b0;
    else             phase_q <= ~phase_q;
  end

  assign tick_o = run_i & (half_i ? phase_q : 1'b1);

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_i && tick_o) |=> !tick_o); // R3
endmodule

// File: rtl/sar_period_ctr.sv
module sar_period_ctr #(
  parameter int TOTAL = 160,
  parameter int SAMP  = 12,
  parameter int BITS  = 8,
  localparam int CW   = $clog2(TOTAL),
  localparam int BW   = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          tick_i,
  output logic          sampling_o,
  output logic          load_msb_o,
  output logic          decide_o,
  output logic [BW-1:0] pos_o,
  output logic          last_o
);
  import sar_seq_pkg::*;

  logic [CW-1:0] cnt_q;
  int            c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    c          = int'(cnt_q);
    sampling_o = (c < SAMP);
    load_msb_o = tick_i && (c == SAMP - 1);
    decide_o   = tick_i && is_decision(c, TOTAL, SAMP, BITS);
    pos_o      = decide_o ? BW'(bit_of(c, TOTAL, SAMP, BITS)) : '0;
    last_o     = tick_i && (c == TOTAL - 1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < TOTAL); // R3
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int BITS = 8,
  localparam int BW  = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            load_msb_i,
  input  logic            decide_i,
  input  logic [BW-1:0]   pos_i,
  input  logic            comp_low_i,
  input  logic            wr_i,
  output logic [BITS-1:0] trial_o,
  output logic [BITS-1:0] result_o
);
  logic [BITS-1:0] trial_q, trial_nxt;

  always_comb begin
    trial_nxt = trial_q;
    if (load_msb_i) begin
      trial_nxt = '0;
      trial_nxt[BITS-1] = 1'b1;
    end else if (decide_i) begin
      if (comp_low_i) trial_nxt[pos_i] = 1'b0;
      if (pos_i != '0) trial_nxt[pos_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= '0;
      result_o <= '0;
    end else begin
      trial_q <= clear_i ? '0 : trial_nxt;
      if (wr_i) result_o <= trial_nxt;
    end
  end

  assign trial_o = trial_q;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(result_o)); // R9
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int TOTAL = 160,
  parameter int SAMP  = 12,
  parameter int BITS  = 8,
  parameter int CHANS = 8,
  localparam int CHW  = $clog2(CHANS),
  localparam int BW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CHW-1:0]  chan_i,
  input  logic            half_clk_i,
  input  logic            comp_low_i,
  output logic [CHW-1:0]  chan_o,
  output logic            sample_o,
  output logic [BITS-1:0] dac_code_o,
  output logic [BITS-1:0] result_o,
  output logic            busy_o,
  output logic            done_o
);
  logic          busy_q, half_q, done_q;
  logic [CHW-1:0] chan_q;
  logic          accept, tick, sampling, load_msb, decide, last;
  logic [BW-1:0] pos;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      chan_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        half_q <= half_clk_i;
        chan_q <= chan_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  sar_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(busy_q), .half_i(half_q), .tick_o(tick)
  );

  sar_period_ctr #(.TOTAL(TOTAL), .SAMP(SAMP), .BITS(BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .tick_i(tick),
    .sampling_o(sampling), .load_msb_o(load_msb), .decide_o(decide),
    .pos_o(pos), .last_o(last)
  );

  sar_code_reg #(.BITS(BITS)) u_code (
    .clk(clk), .rst_n(rst_n), .clear_i(accept | last),
    .load_msb_i(load_msb), .decide_i(decide), .pos_i(pos),
    .comp_low_i(comp_low_i), .wr_i(last),
    .trial_o(dac_code_o), .result_o(result_o)
  );

  assign chan_o   = chan_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign sample_o = busy_q && sampling;

  AST_SAMPLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_code_o == '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(chan_o)); // R2
endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  localparam int N = 160, S = 12, W = (N - S) / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, half = 1'b0;
  logic [2:0] chan = '0;
  logic [2:0] chan_o;
  logic sample_o, busy_o, done_o, comp_low;
  logic [7:0] dac_o, result_o;
  logic [7:0] vin [8];
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  assign comp_low = vin[chan_o] < dac_o;

  sar_conv_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
    .half_clk_i(half), .comp_low_i(comp_low), .chan_o(chan_o),
    .sample_o(sample_o), .dac_code_o(dac_o), .result_o(result_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic conv(input int ch, input bit hf, input logic [7:0] exp,
                      input logic [7:0] prev, input bit inject);
    int d, m, busyc, samc, first_chg;
    bit chan_ok;
    d = hf ? 2 : 1;
    m = 0; busyc = 0; samc = 0; first_chg = 0; chan_ok = 1'b1;
    @(negedge clk);
    start = 1'b1; chan = 3'(ch); half = hf;
    while (!done_o && m < 1000) begin
      @(negedge clk);
      start = 1'b0;
      m++;
      if (busy_o) busyc++;
      if (sample_o) samc++;
      if (busy_o && chan_o != 3'(ch)) chan_ok = 1'b0;
      if (m == S*d + 1) chk(dac_o == 8'h80, "R5 msb trial", dac_o, 8'h80);
      if (m > S*d + 1 && first_chg == 0 && dac_o != 8'h80) first_chg = m;
      if (m == 20) chk(result_o == prev, "R9 result held", result_o, prev);
      if (inject && m == 40) begin start = 1'b1; chan = 3'(ch + 1); half = ~hf; end
    end
    chk(done_o == 1'b1, "R7 done raised", done_o, 1);
    chk(busyc == N*d, "R3 busy length", busyc, N*d);
    chk(samc == S*d, "R4 sample length", samc, S*d);
    chk(first_chg == (S+W)*d + 1, "R6 first decision cycle", first_chg, (S+W)*d + 1);
    chk(result_o == exp, "R6 result", result_o, exp);
    chk(chan_ok, "R2 channel held", chan_o, ch);
    @(negedge clk);
    chk(!done_o, "R7 single pulse", done_o, 0);
    chk(!busy_o, "R8 no restart", busy_o, 0);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    for (int i = 0; i < 8; i++) vin[i] = 8'(i * 37);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !sample_o, "R1 flags in reset", {busy_o, done_o, sample_o}, 0);
    chk(dac_o == 0 && result_o == 0, "R1 codes in reset", {dac_o, result_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && result_o == 0, "R1 after reset", {busy_o, done_o, result_o}, 0);
    prev = 8'h00;
    // R6 R2: every level, target channel differs from the others
    for (int v = 0; v < 256; v++) begin
      int ch;
      ch = v % 8;
      for (int i = 0; i < 8; i++) vin[i] = 8'(v) ^ 8'hA5;
      vin[ch] = 8'(v);
      conv(ch, (v % 16) == 5, 8'(v), prev, 1'b0);
      prev = 8'(v);
    end
    // R3 R8: half clock with a start arriving mid-conversion
    vin[2] = 8'h5C; vin[3] = 8'hF0;
    conv(2, 1'b1, 8'h5C, prev, 1'b1);
    prev = 8'h5C;
    vin[7] = 8'hFF; vin[0] = 8'h01;
    conv(7, 1'b0, 8'hFF, prev, 1'b1);
    repeat (5) @(negedge clk);
    chk(!busy_o && result_o == 8'hFF, "R8 idle after ignored start", result_o, 8'hFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule